// File: doc/BRIEF.md
# Multi-Field Binary Polynomial Reducer

This block takes the double-width product of two binary polynomials and reduces it modulo the fixed irreducible polynomial of one of three preset fields, of degree 163, 233 or 283. Each field has its own fixed XOR network. A network folds the part of the product at and above the field degree back into the low part, multiplied by the polynomial's non-leading terms. The first fold leaves a small overflow, so the network folds that overflow a second time. The three networks run in parallel, and a field-select input steers one of their results to the output through a multiplexer.

The block sits behind a wide GF(2) multiplier in a curve-arithmetic datapath, where the set of field sizes is known when the chip is designed. The product of a smaller field is placed in the least significant bits of the product input, and the upper bits are held at zero. An optional output register, enabled by a parameter and enabled by default, gives the block one cycle of latency and an asynchronous active-low reset. The block has no state machine. Apart from the optional register it is pure combinational logic.

Top module: `poly_reducer`

## Requirements
- R1: With field select 2'b00, the output bits [162:0] equal the product bits [324:0] reduced modulo x^163 + x^7 + x^6 + x^3 + 1.
- R2: With field select 2'b01, the output bits [232:0] equal the product bits [464:0] reduced modulo x^233 + x^74 + 1.
- R3: With field select 2'b10, the output bits [282:0] equal the full 565-bit product reduced modulo x^283 + x^12 + x^7 + x^5 + 1. This holds for the all-ones product and for a product with only its top bit set.
- R4: With field select 2'b11, the output is all zeros for any product.
- R5: With field select 2'b00 or 2'b01, every output bit at or above the selected degree (bit 163 or bit 233 upward) is zero.
- R6: With the output register enabled, the output shows the result of the inputs present at the previous rising clock edge and does not change between edges. While reset is low, the output is zero.
- R7: A product with no bits at or above the selected degree passes to the output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Asynchronous active-low reset of the output register |
| prod_i | input | 565 | Double-width product; smaller fields use the low 2m-1 bits |
| sel_i | input | 2 | Field select: 00 = 163, 01 = 233, 10 = 283, 11 = none |
| res_o | output | 283 | Reduced result, zero-extended above the selected degree |

## Verification
The bench compares every field against a bit-serial long-division model. It covers random products, the all-ones product and the single-top-bit product. A missing second fold or a wrong tap position would therefore leave overflow bits or flip low bits. Products that are already reduced must come out unchanged, which exposes a network that folds bits it should leave alone. The unused select code and the zero bits above a small field's degree expose a multiplexer that leaks another network's result. A latency probe between clock edges and a check during reset catch an output stage that is transparent or resets to the wrong value.

// File: rtl/red_pkg.sv
package red_pkg;
    // Field degrees supported by the reducer
    localparam int unsigned DEG_A = 163;
    localparam int unsigned DEG_B = 233;
    localparam int unsigned DEG_C = 283;

    // Non-leading, non-constant terms of each irreducible polynomial
    localparam int unsigned A_T1 = 7;
    localparam int unsigned A_T2 = 6;
    localparam int unsigned A_T3 = 3;
    localparam int unsigned B_T1 = 74;
    localparam int unsigned C_T1 = 12;
    localparam int unsigned C_T2 = 7;
    localparam int unsigned C_T3 = 5;

    typedef enum logic [1:0] {
        FLD_A    = 2'b00,
        FLD_B    = 2'b01,
        FLD_C    = 2'b10,
        FLD_NONE = 2'b11
    } field_e;
endpackage

// File: rtl/fold_net.sv
module fold_net #(
    parameter int unsigned M     = 163,
    parameter int unsigned K1    = 7,
    parameter int unsigned K2    = 6,
    parameter int unsigned K3    = 3,
    parameter int unsigned NT    = 3,
    parameter int unsigned W_OUT = 283
) (
    input  logic [2*M-2:0]   prod_i,
    output logic [W_OUT-1:0] res_o
);
    localparam int unsigned PW = 2*M - 1;
    localparam int unsigned HW = M - 1;

    function automatic int unsigned tap_pos(input int i);
        return (i == 0) ? K1 : ((i == 1) ? K2 : K3);
    endfunction

    logic [HW-1:0] hi1;
    logic [HW-1:0] hi2;
    logic [PW-1:0] stage1;
    logic [M-1:0]  stage2;

    // First fold: upper half times the low terms, added into the low half
    always_comb begin
        hi1    = prod_i[PW-1:M];
        stage1 = {{HW{1'b0}}, prod_i[M-1:0]} ^ PW'(hi1);
        for (int i = 0; i < 3; i++) begin
            if (i < int'(NT)) begin
                stage1 = stage1 ^ (PW'(hi1) << tap_pos(i));
            end
        end
    end

    // Second fold: the short overflow left by the first fold
    always_comb begin
        hi2    = stage1[PW-1:M];
        stage2 = stage1[M-1:0] ^ M'(hi2);
        for (int i = 0; i < 3; i++) begin
            if (i < int'(NT)) begin
                stage2 = stage2 ^ (M'(hi2) << tap_pos(i));
            end
        end
    end

    assign res_o = W_OUT'(stage2);
endmodule

// File: rtl/field_mux.sv
module field_mux
    import red_pkg::*;
#(
    parameter int unsigned W = 283
) (
    input  field_e         sel_i,
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    input  logic [W-1:0]   c_i,
    output logic [W-1:0]   y_o
);
    always_comb begin
        unique case (sel_i)
            FLD_A:    y_o = a_i;
            FLD_B:    y_o = b_i;
            FLD_C:    y_o = c_i;
            FLD_NONE: y_o = '0;
            default:  y_o = '0;
        endcase
    end
endmodule

// File: rtl/poly_reducer.sv
module poly_reducer
    import red_pkg::*;
#(
    parameter int unsigned W       = DEG_C,
    parameter bit          REG_OUT = 1'b1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [2*W-2:0]    prod_i,
    input  logic [1:0]        sel_i,
    output logic [W-1:0]      res_o
);
    localparam int unsigned PW = 2*W - 1;

    logic [W-1:0] res_a;
    logic [W-1:0] res_b;
    logic [W-1:0] res_c;
    logic [W-1:0] res_sel;

    fold_net #(.M(DEG_A), .K1(A_T1), .K2(A_T2), .K3(A_T3), .NT(3), .W_OUT(W)) u_net_a (
        .prod_i (prod_i[2*DEG_A-2:0]),
        .res_o  (res_a)
    );

    fold_net #(.M(DEG_B), .K1(B_T1), .K2(0), .K3(0), .NT(1), .W_OUT(W)) u_net_b (
        .prod_i (prod_i[2*DEG_B-2:0]),
        .res_o  (res_b)
    );

    fold_net #(.M(DEG_C), .K1(C_T1), .K2(C_T2), .K3(C_T3), .NT(3), .W_OUT(W)) u_net_c (
        .prod_i (prod_i[2*DEG_C-2:0]),
        .res_o  (res_c)
    );

    field_mux #(.W(W)) u_mux (
        .sel_i (field_e'(sel_i)),
        .a_i   (res_a),
        .b_i   (res_b),
        .c_i   (res_c),
        .y_o   (res_sel)
    );

    generate
        if (REG_OUT) begin : g_reg
            logic [W-1:0] res_q;

            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) begin
                    res_q <= '0;
                end else begin
                    res_q <= res_sel;
                end
            end

            assign res_o = res_q;

            // R4
            sel_none_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (sel_i == 2'b11) |=> (res_o == '0));

            // R5
            small_a_upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (sel_i == 2'b00) |=> (res_o[W-1:DEG_A] == '0));

            // R5
            small_b_upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (sel_i == 2'b01) |=> (res_o[W-1:DEG_B] == '0));

            // R7
            reduced_pass_c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (sel_i == 2'b10 && prod_i[PW-1:W] == '0) |=> (res_o == $past(prod_i[W-1:0])));

            // R7
            reduced_pass_a_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (sel_i == 2'b00 && prod_i[PW-1:DEG_A] == '0)
                |=> (res_o[DEG_A-1:0] == $past(prod_i[DEG_A-1:0])));
        end else begin : g_comb
            assign res_o = res_sel;
        end
    endgenerate
endmodule

// File: tb/sim_poly_reducer.sv
`timescale 1ns/1ps
module sim_poly_reducer;
    localparam int W  = 283;
    localparam int PW = 2*W - 1;

    // Stimulus table: {field select, pattern}; pattern 0 random, 1 all ones,
    // 2 single top bit, 3 already reduced
    localparam logic [3:0] VEC [0:15] = '{
        4'b00_01, 4'b00_10, 4'b00_11, 4'b00_00,
        4'b01_01, 4'b01_10, 4'b01_11, 4'b01_00,
        4'b10_01, 4'b10_10, 4'b10_11, 4'b10_00,
        4'b11_01, 4'b11_00, 4'b11_10, 4'b11_11
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [PW-1:0] prod = '0;
    logic [1:0]    sel = 2'b00;
    logic [W-1:0]  res;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    poly_reducer u0 (
        .clk_i  (clk),
        .rst_ni (rst_n),
        .prod_i (prod),
        .sel_i  (sel),
        .res_o  (res)
    );

    function automatic int deg_of(input logic [1:0] s);
        return (s == 2'b00) ? 163 : ((s == 2'b01) ? 233 : 283);
    endfunction

    function automatic logic [PW:0] poly_of(input logic [1:0] s);
        logic [PW:0] p;
        p = '0;
        p[0] = 1'b1;
        if (s == 2'b00) begin p[163] = 1; p[7] = 1; p[6] = 1; p[3] = 1; end
        else if (s == 2'b01) begin p[233] = 1; p[74] = 1; end
        else begin p[283] = 1; p[12] = 1; p[7] = 1; p[5] = 1; end
        return p;
    endfunction

    // Bit-serial long division reference
    function automatic logic [W-1:0] ref_red(input logic [PW-1:0] p_in, input logic [1:0] s);
        logic [PW:0] t;
        logic [PW:0] pl;
        int m;
        if (s == 2'b11) return '0;
        m  = deg_of(s);
        pl = poly_of(s);
        t  = {1'b0, p_in};
        for (int b = 2*m - 2; b >= m; b--) begin
            if (t[b]) t = t ^ (pl << (b - m));
        end
        for (int b = m; b < W; b++) t[b] = 1'b0;
        return t[W-1:0];
    endfunction

    function automatic logic [PW-1:0] rand_wide();
        logic [575:0] v;
        for (int k = 0; k < 18; k++) v[k*32 +: 32] = $urandom;
        return v[PW-1:0];
    endfunction

    function automatic logic [PW-1:0] make_stim(input logic [1:0] s, input logic [1:0] pat);
        logic [PW-1:0] mask;
        logic [PW-1:0] v;
        int m;
        m    = (s == 2'b11) ? 283 : deg_of(s);
        mask = '0;
        for (int b = 0; b < 2*m - 1; b++) mask[b] = 1'b1;
        case (pat)
            2'd0: v = rand_wide() & mask;
            2'd1: v = mask;
            2'd2: begin v = '0; v[2*m-2] = 1'b1; end
            default: begin
                v = rand_wide();
                for (int b = m; b < PW; b++) v[b] = 1'b0;
            end
        endcase
        return v;
    endfunction

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic string req_of(input logic [1:0] s, input logic [1:0] pat);
        if (s == 2'b11) return "R4";
        if (pat == 2'd3) return "R7";
        return (s == 2'b00) ? "R1" : ((s == 2'b01) ? "R2" : "R3");
    endfunction

    // Drive at a falling edge, let one rising edge capture, sample at the next fall
    task automatic apply_and_check(input logic [1:0] s, input logic [PW-1:0] p, input string req);
        logic [W-1:0] e;
        int m;
        sel  = s;
        prod = p;
        e    = ref_red(p, s);
        @(posedge clk);
        @(negedge clk);
        check(req, res, e);
        if (s == 2'b00 || s == 2'b01) begin
            m = deg_of(s);
            for (int b = m; b < W; b++) begin
                if (res[b] !== 1'b0) begin
                    check("R5", res, e);
                    break;
                end
            end
            n_chk++;
        end
    endtask

    initial begin
        logic [W-1:0] first_exp;
        logic [PW-1:0] p2;
        // R6: reset holds output at zero even with live inputs
        sel  = 2'b10;
        prod = make_stim(2'b10, 2'd1);
        repeat (3) @(negedge clk);
        check("R6", res, '0);
        rst_n = 1'b1;
        @(negedge clk);

        foreach (VEC[i]) begin
            apply_and_check(VEC[i][3:2], make_stim(VEC[i][3:2], VEC[i][1:0]),
                            req_of(VEC[i][3:2], VEC[i][1:0]));
        end

        for (int f = 0; f < 3; f++) begin
            for (int n = 0; n < 25; n++) begin
                apply_and_check(2'(f), make_stim(2'(f), 2'd0), req_of(2'(f), 2'd0));
            end
        end

        // R6: one-cycle latency, output stable between edges
        apply_and_check(2'b00, make_stim(2'b00, 2'd1), "R1");
        first_exp = ref_red(make_stim(2'b00, 2'd1), 2'b00);
        p2   = make_stim(2'b10, 2'd0);
        sel  = 2'b10;
        prod = p2;
        #1;
        check("R6", res, first_exp);
        @(posedge clk);
        @(negedge clk);
        check("R6", res, ref_red(p2, 2'b10));

        // R6: asynchronous reset clears a nonzero output
        rst_n = 1'b0;
        #1;
        check("R6", res, '0);
        rst_n = 1'b1;

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule